// File: doc/BRIEF.md
# Branch Resolve and Next-PC Unit

This block owns the program counter of a 32-bit RISC core whose architecture exposes one branch delay slot. Each time the core advances (`step` high), the block resolves the control-transfer kind of the instruction at the current PC. It uses the two register operands, the 16-bit branch offset and the 26-bit jump field. It reports whether the transfer is taken, and it raises a link-write request with its register number and value.

The instruction after a branch or jump always executes. A taken transfer therefore does not redirect the very next PC. The target is parked in a one-entry pending register, the PC steps sequentially once into the delay slot, and the following step loads the parked target. Link values point past the delay slot (PC+8). No condition codes exist: every decision comes straight from comparing register values.

Kind encoding on `ctl_kind`: 0 none, 1 equal, 2 not-equal, 3 less-or-equal-zero, 4 greater-than-zero, 5 less-than-zero, 6 greater-or-equal-zero, 7 less-than-zero-and-link, 8 greater-or-equal-zero-and-link, 9 jump, 10 jump-and-link, 11 jump-register, 12 jump-register-and-link. Codes 13 to 15 behave as 0.

Top module: `br_next_pc`

## Requirements
- R1: After reset, `pc` equals `RESET_PC` and no redirect is pending. While `step` is low, `pc` holds, `taken` and `link_we` stay low, and `next_pc` equals `pc`.
- R2: Kinds 1 and 2 are taken when `opa == opb` and when `opa != opb` respectively. Their target is pc+4 plus the sign-extended offset shifted left by 2.
- R3: Kinds 3, 4, 5 and 6 compare `opa` as a signed value against zero for <=0, >0, <0 and >=0. Kinds 7 and 8 use the tests of 5 and 6. All of these use the target of R2.
- R4: Kinds 9 and 10 are always taken, with the target {pc+4 bits 31:28, jump field, 2'b00}.
- R5: Kinds 11 and 12 are always taken, with the full 32-bit `opa` as the target.
- R6: When a step occurs with no pending redirect, `next_pc` is pc+4 and `pc` takes that value at the clock edge.
- R7: A taken transfer sets the pending redirect. The instruction that follows (the delay slot) still sees `next_pc` = its pc+4 unless a redirect was already pending. The step after the delay slot loads the parked target.
- R8: When a transfer is taken in the delay slot of an earlier taken transfer, the earlier target is loaded first. The newer target is then parked for one more step.
- R9: Kinds 7, 8 and 10 request a write of pc+8 into register 31 whether or not they are taken.
- R10: Kind 12 requests a write of pc+8 into register `link_rd`. When `link_rd` is 0 the request is suppressed, so register 0 is never written.
- R11: Kinds 0 and 13 to 15 are not taken and raise no link request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Core advances past the instruction at `pc` this cycle |
| ctl_kind | input | 4 | Decoded transfer kind (encoding above) |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| br_off | input | 16 | Branch offset in words |
| j_field | input | 26 | Jump target field in words |
| link_rd | input | 5 | Destination register of kind 12 |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | PC loaded at the next edge |
| taken | output | 1 | Current transfer is taken |
| link_we | output | 1 | Link-write request |
| link_addr | output | 5 | Register written by the link |
| link_data | output | 32 | Link value (pc+8) |

## Verification
The hardest case to reach is a taken transfer placed in the delay slot of another taken transfer. Here the pending register is consumed and refilled in the same step. The stimulus reaches it by issuing a taken jump and then, as the very next instruction, a taken branch, followed by plain instructions. The expected sequence is then the first target, then the second target. A stall with a taken-looking branch on the inputs also sits between a transfer and its delay slot, to show that the parked target survives idle cycles.

// File: rtl/br_next_pc.sv
module br_next_pc #(
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic [3:0]  ctl_kind,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  input  logic [15:0] br_off,
  input  logic [25:0] j_field,
  input  logic [4:0]  link_rd,
  output logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        taken,
  output logic        link_we,
  output logic [4:0]  link_addr,
  output logic [31:0] link_data
);

  localparam logic [4:0] RA_REG = 5'd31;

  logic [31:0] pend_tgt;
  logic        pend_v;
  logic [31:0] seq_pc;
  logic [31:0] rel_tgt;
  logic [31:0] abs_tgt;
  logic [31:0] tgt;
  logic        cond;
  logic        wants_link;
  logic        neg;
  logic        zero;

  assign seq_pc    = pc + 32'd4;
  assign rel_tgt   = seq_pc + {{14{br_off[15]}}, br_off, 2'b00};
  assign abs_tgt   = {seq_pc[31:28], j_field, 2'b00};
  assign neg       = opa[31];
  assign zero      = (opa == 32'd0);
  assign link_data = pc + 32'd8;

  always_comb begin
    cond       = 1'b0;
    tgt        = rel_tgt;
    wants_link = 1'b0;
    link_addr  = RA_REG;
    case (ctl_kind)
      4'd1:  cond = (opa == opb);
      4'd2:  cond = (opa != opb);
      4'd3:  cond = neg | zero;
      4'd4:  cond = ~neg & ~zero;
      4'd5:  cond = neg;
      4'd6:  cond = ~neg;
      4'd7:  begin cond = neg;  wants_link = 1'b1; end
      4'd8:  begin cond = ~neg; wants_link = 1'b1; end
      4'd9:  begin cond = 1'b1; tgt = abs_tgt; end
      4'd10: begin cond = 1'b1; tgt = abs_tgt; wants_link = 1'b1; end
      4'd11: begin cond = 1'b1; tgt = opa; end
      4'd12: begin
        cond       = 1'b1;
        tgt        = opa;
        wants_link = (link_rd != 5'd0);
        link_addr  = link_rd;
      end
      default: cond = 1'b0;
    endcase
  end

  assign taken   = step & cond;
  assign link_we = step & wants_link;
  assign next_pc = !step ? pc : (pend_v ? pend_tgt : seq_pc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc       <= RESET_PC;
      pend_v   <= 1'b0;
      pend_tgt <= 32'd0;
    end else if (step) begin
      pc     <= next_pc;
      pend_v <= cond;
      if (cond) pend_tgt <= tgt;
    end
  end

endmodule

module br_next_pc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic        taken,
  input logic        link_we,
  input logic [4:0]  link_addr,
  input logic [31:0] link_data,
  input logic        pend_v,
  input logic [31:0] pend_tgt
);

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc)); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !pend_v |-> next_pc == pc + 32'd4); // R6

  AST_PARK_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> pend_v); // R7

  AST_LOAD_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    step && pend_v |=> pc == $past(pend_tgt)); // R8

  AST_LINK_PAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_data == pc + 32'd8); // R9

  AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_addr != 5'd0); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> !taken && !link_we); // R1

endmodule

bind br_next_pc br_next_pc_chk u_chk (.*);

// File: tb/br_next_pc_bench.sv
module br_next_pc_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [3:0]  ctl_kind = 4'd0;
  logic [31:0] opa = 32'd0, opb = 32'd0;
  logic [15:0] br_off = 16'd0;
  logic [25:0] j_field = 26'd0;
  logic [4:0]  link_rd = 5'd0;
  logic [31:0] pc, next_pc, link_data;
  logic        taken, link_we;
  logic [4:0]  link_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  br_next_pc #(.RESET_PC(RPC)) u_br_next_pc (
    .clk(clk), .rst_n(rst_n), .step(step), .ctl_kind(ctl_kind),
    .opa(opa), .opb(opb), .br_off(br_off), .j_field(j_field),
    .link_rd(link_rd), .pc(pc), .next_pc(next_pc), .taken(taken),
    .link_we(link_we), .link_addr(link_addr), .link_data(link_data));

  typedef struct {
    string       req;
    logic [31:0] pc;
    logic [31:0] npc;
    logic        tk;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  logic [31:0] m_pc;
  logic        m_pv;
  logic [31:0] m_pt;

  task automatic issue(input string req, input logic st, input logic [3:0] k,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] off, input logic [25:0] jf,
                       input logic [4:0] rd);
    exp_t e;
    logic c, lk;
    logic [31:0] t, s;
    logic [4:0] la;
    @(negedge clk);
    step = st; ctl_kind = k; opa = a; opb = b; br_off = off; j_field = jf; link_rd = rd;
    s = m_pc + 32'd4;
    c = 1'b0; lk = 1'b0; la = 5'd31;
    t = s + {{14{off[15]}}, off, 2'b00};
    case (k)
      4'd1: c = (a == b);
      4'd2: c = (a != b);
      4'd3: c = ($signed(a) <= 0);
      4'd4: c = ($signed(a) > 0);
      4'd5: c = ($signed(a) < 0);
      4'd6: c = ($signed(a) >= 0);
      4'd7: begin c = ($signed(a) < 0);  lk = 1'b1; end
      4'd8: begin c = ($signed(a) >= 0); lk = 1'b1; end
      4'd9: begin c = 1'b1; t = {s[31:28], jf, 2'b00}; end
      4'd10: begin c = 1'b1; t = {s[31:28], jf, 2'b00}; lk = 1'b1; end
      4'd11: begin c = 1'b1; t = a; end
      4'd12: begin c = 1'b1; t = a; lk = (rd != 5'd0); la = rd; end
      default: c = 1'b0;
    endcase
    e.req = req;
    e.pc  = m_pc;
    e.npc = !st ? m_pc : (m_pv ? m_pt : s);
    e.tk  = st & c;
    e.we  = st & lk;
    e.wa  = la;
    e.wd  = m_pc + 32'd8;
    q.push_back(e);
    if (st) begin
      m_pc = e.npc;
      m_pv = c;
      if (c) m_pt = t;
    end
  endtask

  task automatic plain(input string req);
    issue(req, 1'b1, 4'd0, 32'd0, 32'd0, 16'd0, 26'd0, 5'd0);
  endtask

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.req, "pc", pc, e.pc);
        cmp(e.req, "next_pc", next_pc, e.npc);
        cmp(e.req, "taken", {31'd0, taken}, {31'd0, e.tk});
        cmp(e.req, "link_we", {31'd0, link_we}, {31'd0, e.we});
        if (e.we) begin
          cmp(e.req, "link_addr", {27'd0, link_addr}, {27'd0, e.wa});
          cmp(e.req, "link_data", link_data, e.wd);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_pc = RPC; m_pv = 1'b0; m_pt = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and idle hold
    issue("R1", 1'b0, 4'd1, 32'd5, 32'd5, 16'd8, 26'd0, 5'd0);
    issue("R1", 1'b0, 4'd0, 32'd0, 32'd0, 16'd0, 26'd0, 5'd0);
    // R6 sequential
    plain("R6"); plain("R6");
    // R2 equal taken, R7 delay slot
    issue("R2", 1'b1, 4'd1, 32'd7, 32'd7, 16'd4, 26'd0, 5'd0);
    plain("R7"); plain("R7");
    issue("R2", 1'b1, 4'd1, 32'd7, 32'd8, 16'd4, 26'd0, 5'd0);
    plain("R2");
    issue("R2", 1'b1, 4'd2, 32'd1, 32'd2, 16'hFFF0, 26'd0, 5'd0);
    plain("R7"); plain("R7");
    issue("R2", 1'b1, 4'd2, 32'd3, 32'd3, 16'd4, 26'd0, 5'd0);
    plain("R2");
    // R3 zero compares
    issue("R3", 1'b1, 4'd3, 32'd0, 32'd0, 16'd2, 26'd0, 5'd0); plain("R3"); plain("R3");
    issue("R3", 1'b1, 4'd3, 32'd1, 32'd0, 16'd2, 26'd0, 5'd0); plain("R3");
    issue("R3", 1'b1, 4'd4, 32'd0, 32'd0, 16'd2, 26'd0, 5'd0); plain("R3");
    issue("R3", 1'b1, 4'd4, 32'd9, 32'd0, 16'd2, 26'd0, 5'd0); plain("R3"); plain("R3");
    issue("R3", 1'b1, 4'd5, 32'h8000_0000, 32'd0, 16'd3, 26'd0, 5'd0); plain("R3"); plain("R3");
    issue("R3", 1'b1, 4'd5, 32'd0, 32'd0, 16'd3, 26'd0, 5'd0); plain("R3");
    issue("R3", 1'b1, 4'd6, 32'd0, 32'd0, 16'd3, 26'd0, 5'd0); plain("R3"); plain("R3");
    issue("R3", 1'b1, 4'd6, 32'hFFFF_FFFF, 32'd0, 16'd3, 26'd0, 5'd0); plain("R3");
    // R9 link forms, taken and not
    issue("R9", 1'b1, 4'd7, 32'd5, 32'd0, 16'd6, 26'd0, 5'd0); plain("R9");
    issue("R9", 1'b1, 4'd7, 32'hFFFF_FFF0, 32'd0, 16'd6, 26'd0, 5'd0); plain("R9"); plain("R9");
    issue("R9", 1'b1, 4'd8, 32'hFFFF_FFF0, 32'd0, 16'd6, 26'd0, 5'd0); plain("R9");
    issue("R9", 1'b1, 4'd8, 32'd0, 32'd0, 16'd6, 26'd0, 5'd0); plain("R9"); plain("R9");
    // R4 jumps
    issue("R4", 1'b1, 4'd9, 32'd0, 32'd0, 16'd0, 26'h0ABCDE, 5'd0); plain("R4"); plain("R4");
    issue("R4", 1'b1, 4'd10, 32'd0, 32'd0, 16'd0, 26'h0001000, 5'd0); plain("R4"); plain("R4");
    // R5 / R10 register jumps
    issue("R5", 1'b1, 4'd11, 32'h2000_0040, 32'd0, 16'd0, 26'd0, 5'd0); plain("R5"); plain("R5");
    issue("R10", 1'b1, 4'd12, 32'h2000_0100, 32'd0, 16'd0, 26'd0, 5'd0); plain("R10"); plain("R10");
    issue("R10", 1'b1, 4'd12, 32'h2000_0200, 32'd0, 16'd0, 26'd0, 5'd5); plain("R10"); plain("R10");
    // R8 transfer in delay slot, with a stall in between
    issue("R8", 1'b1, 4'd9, 32'd0, 32'd0, 16'd0, 26'h0000400, 5'd0);
    issue("R1", 1'b0, 4'd1, 32'd1, 32'd1, 16'd9, 26'd0, 5'd0);
    issue("R8", 1'b1, 4'd1, 32'd4, 32'd4, 16'd16, 26'd0, 5'd0);
    plain("R8"); plain("R8"); plain("R8");
    // R11 undefined kinds
    issue("R11", 1'b1, 4'd13, 32'd0, 32'd0, 16'd4, 26'h1, 5'd3);
    issue("R11", 1'b1, 4'd15, 32'd0, 32'd0, 16'd4, 26'h1, 5'd3);
    plain("R11");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule